// File: doc/BRIEF.md
# Warp Predicate Prefix Counter

This unit takes one predicate bit from each lane of a 32-lane group. It packs those bits into a single ballot word. From that word it produces a prefix count for every lane and a total count for the whole group. A lane's prefix count is the number of true predicates inside a window of lanes. The window is set by the lane's own position and by a 2-bit scan mode. The mode picks forward or reverse direction, and whether the lane's own predicate is included or excluded.

Each lane's count is the population count of the ballot ANDed with a per-lane mask. Because of this, all 32 results come from the one ballot word in a single step, with no chain of adder stages between lanes. The unit samples its inputs when a valid strobe is high and shows the results one clock later, with a matching valid flag. Typical users are stream compaction and split logic, which need a scatter index for each lane.

Top module: `pfx_warp_count`

## Requirements
- R1: Bit k of `out_ballot` equals the predicate `in_pred[k]` of lane k, as captured with the last accepted strobe.
- R2: `out_total` equals the number of ones in `out_ballot`, from 0 up to 32.
- R3: With mode 2'b00, lane k's result is the number of true predicates in lanes j < k. This is a forward exclusive scan, so lane 0 reads 0.
- R4: With mode 2'b01, lane k's result counts true predicates in lanes j <= k. This is a forward inclusive scan, so lane 31 equals the total.
- R5: With mode 2'b10, lane k's result counts true predicates in lanes j > k. This is a reverse exclusive scan, so lane 31 reads 0.
- R6: With mode 2'b11, lane k's result counts true predicates in lanes j >= k. This is a reverse inclusive scan, so lane 0 equals the total.
- R7: Lane k's result sits in `out_prefix[k*6 +: 6]`. Each field is 6 bits wide, so the value 32 is represented exactly.
- R8: When `in_valid` is high at a rising edge, the results for those inputs appear after that edge. `out_valid` is high for exactly the cycle that follows each accepted strobe.
- R9: While `in_valid` is low, changes on `in_pred` and `in_mode` leave `out_ballot`, `out_total` and `out_prefix` unchanged.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_ballot`, `out_total` and every prefix field to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that samples predicates and mode |
| in_pred | input | 32 | One predicate bit per lane |
| in_mode | input | 2 | Scan mode: 00 fwd excl, 01 fwd incl, 10 rev excl, 11 rev incl |
| out_valid | output | 1 | High for the cycle that follows an accepted strobe |
| out_ballot | output | 32 | Captured ballot word |
| out_total | output | 6 | Population count of the ballot |
| out_prefix | output | 192 | Per-lane prefix counts, 6 bits per lane, lane 0 in the low bits |

## Verification
The bench builds the unit with its default parameters: 32 lanes and 6-bit counts. At that size, an all-ones ballot drives lane 0 in reverse inclusive mode and lane 31 in forward inclusive mode to the full value 32. That makes the top code of each 6-bit field observable. The same size lets the lowest and highest lanes hit every mask edge: an empty window, a full window, and a window that holds only the lane itself.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    localparam int DEF_LANES = 32;

    typedef enum logic [1:0] {
        SCAN_FWD_EXCL = 2'b00,
        SCAN_FWD_INCL = 2'b01,
        SCAN_REV_EXCL = 2'b10,
        SCAN_REV_INCL = 2'b11
    } scan_mode_e;

endpackage

// File: rtl/pfx_mask_gen.sv
module pfx_mask_gen
    import pfx_pkg::*;
#(
    parameter int LANES    = DEF_LANES,
    parameter int LANE_IDX = 0
) (
    input  scan_mode_e       mode,
    output logic [LANES-1:0] mask
);
    logic [LANES-1:0] below;
    logic [LANES-1:0] self_bit;
    logic [LANES-1:0] above;

    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            below[j]    = (j < LANE_IDX);
            self_bit[j] = (j == LANE_IDX);
            above[j]    = (j > LANE_IDX);
        end
        unique case (mode)
            SCAN_FWD_EXCL: mask = below;
            SCAN_FWD_INCL: mask = below | self_bit;
            SCAN_REV_EXCL: mask = above;
            SCAN_REV_INCL: mask = above | self_bit;
            default:       mask = '0;
        endcase
    end
endmodule

// File: rtl/pfx_popcnt.sv
module pfx_popcnt #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(bits[i]);
        end
    end
endmodule

// File: rtl/pfx_warp_count.sv
module pfx_warp_count
    import pfx_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int CNT_W = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [LANES-1:0]       in_pred,
    input  logic [1:0]             in_mode,
    output logic                   out_valid,
    output logic [LANES-1:0]       out_ballot,
    output logic [CNT_W-1:0]       out_total,
    output logic [LANES*CNT_W-1:0] out_prefix
);
    localparam int PFX_W = LANES * CNT_W;

    scan_mode_e         mode_q;
    logic [CNT_W-1:0]   total_d;
    logic [PFX_W-1:0]   prefix_d;

    assign mode_q = scan_mode_e'(in_mode);

    pfx_popcnt #(.W(LANES), .CW(CNT_W)) u_total (
        .bits (in_pred),
        .cnt  (total_d)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANES-1:0] lane_mask;
        logic [CNT_W-1:0] lane_cnt;

        pfx_mask_gen #(.LANES(LANES), .LANE_IDX(k)) u_mask (
            .mode (mode_q),
            .mask (lane_mask)
        );

        pfx_popcnt #(.W(LANES), .CW(CNT_W)) u_cnt (
            .bits (in_pred & lane_mask),
            .cnt  (lane_cnt)
        );

        assign prefix_d[k*CNT_W +: CNT_W] = lane_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_ballot <= '0;
            out_total  <= '0;
            out_prefix <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_ballot <= in_pred;
                out_total  <= total_d;
                out_prefix <= prefix_d;
            end
        end
    end
endmodule

// File: rtl/pfx_warp_count_chk.sv
module pfx_warp_count_chk #(
    parameter int LANES = 32,
    parameter int CNT_W = 6
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic [LANES-1:0]       in_pred,
    input logic [1:0]             in_mode,
    input logic                   out_valid,
    input logic [LANES-1:0]       out_ballot,
    input logic [CNT_W-1:0]       out_total,
    input logic [LANES*CNT_W-1:0] out_prefix
);
    logic [CNT_W-1:0] first_lane;
    logic [CNT_W-1:0] last_lane;
    assign first_lane = out_prefix[CNT_W-1:0];
    assign last_lane  = out_prefix[LANES*CNT_W-1 -: CNT_W];

    // R1
    ballot_capture_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_ballot == $past(in_pred));

    // R2
    total_count_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_total == CNT_W'($countones(out_ballot)));

    // R3
    fwd_excl_first_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b00) |=> first_lane == '0);

    // R4
    fwd_incl_last_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b01) |=> last_lane == out_total);

    // R5
    rev_excl_last_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b10) |=> last_lane == '0);

    // R6
    rev_incl_first_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b11) |=> first_lane == out_total);

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_ballot) && $stable(out_total) && $stable(out_prefix));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !out_valid && out_ballot == '0 && out_total == '0 && out_prefix == '0);
endmodule

bind pfx_warp_count pfx_warp_count_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_pred    (in_pred),
    .in_mode    (in_mode),
    .out_valid  (out_valid),
    .out_ballot (out_ballot),
    .out_total  (out_total),
    .out_prefix (out_prefix)
);

// File: tb/pfx_warp_count_tb.sv
`timescale 1ns/1ps
module pfx_warp_count_tb;
    localparam int LANES = 32;
    localparam int CW    = 6;

    typedef struct packed {
        logic [31:0] pred;
        logic [1:0]  mode;
        logic [5:0]  total;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 2'b00, 6'd0},
        '{32'hFFFF_FFFF, 2'b00, 6'd32},
        '{32'hFFFF_FFFF, 2'b01, 6'd32},
        '{32'hFFFF_FFFF, 2'b10, 6'd32},
        '{32'hFFFF_FFFF, 2'b11, 6'd32},
        '{32'h8000_0001, 2'b01, 6'd2},
        '{32'hAAAA_AAAA, 2'b10, 6'd16},
        '{32'h0000_0001, 2'b11, 6'd1},
        '{32'h1234_5678, 2'b00, 6'd13},
        '{32'hF0F0_0F0F, 2'b01, 6'd16}
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic [LANES-1:0]    in_pred = '0;
    logic [1:0]          in_mode = 2'b00;
    logic                out_valid;
    logic [LANES-1:0]    out_ballot;
    logic [CW-1:0]       out_total;
    logic [LANES*CW-1:0] out_prefix;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pfx_warp_count u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_pred    (in_pred),
        .in_mode    (in_mode),
        .out_valid  (out_valid),
        .out_ballot (out_ballot),
        .out_total  (out_total),
        .out_prefix (out_prefix)
    );

    function automatic int exp_lane(logic [31:0] p, logic [1:0] m, int k);
        int c = 0;
        for (int j = 0; j < LANES; j++) begin
            bit in_win;
            case (m)
                2'b00:   in_win = (j < k);
                2'b01:   in_win = (j <= k);
                2'b10:   in_win = (j > k);
                default: in_win = (j >= k);
            endcase
            if (in_win && p[j]) c++;
        end
        return c;
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string mode_req(logic [1:0] m);
        case (m)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic apply(logic [31:0] p, logic [1:0] m);
        @(negedge clk);
        in_pred  = p;
        in_mode  = m;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_all(logic [31:0] p, logic [1:0] m, int tot);
        check("R8 out_valid", out_valid, 1);
        check("R1 ballot", out_ballot, p);
        check("R2 total", out_total, tot);
        for (int k = 0; k < LANES; k++) begin
            // R7: lane k field at k*6
            check({mode_req(m), "/R7 lane"}, out_prefix[k*CW +: CW], exp_lane(p, m, k));
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 valid", out_valid, 0);
        check("R10 ballot", out_ballot, 0);
        check("R10 total", out_total, 0);
        check("R10 prefix", (out_prefix == '0), 1);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            apply(VECS[v].pred, VECS[v].mode);
            check_all(VECS[v].pred, VECS[v].mode, int'(VECS[v].total));
        end

        // R8: valid lasts a single cycle
        @(negedge clk);
        check("R8 valid drop", out_valid, 0);

        // R9: inputs ignored without strobe
        apply(32'h0F00_00F0, 2'b01);
        in_pred = 32'hFFFF_0000;
        in_mode = 2'b11;
        @(negedge clk);
        @(negedge clk);
        check("R9 valid", out_valid, 0);
        check("R9 ballot", out_ballot, 32'h0F00_00F0);
        check("R9 total", out_total, 8);
        for (int k = 0; k < LANES; k++)
            check("R9 lane", out_prefix[k*CW +: CW], exp_lane(32'h0F00_00F0, 2'b01, k));

        // R8: back-to-back strobes
        @(negedge clk);
        in_valid = 1'b1; in_pred = 32'h0000_00FF; in_mode = 2'b00;
        @(negedge clk);
        check("R8 b2b first", out_total, 8);
        in_pred = 32'h0000_0003; in_mode = 2'b10;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 b2b valid", out_valid, 1);
        check("R8 b2b second", out_total, 2);
        check("R5 b2b lane0", out_prefix[CW-1:0], 1);

        // R10: reset mid-run
        apply(32'hFFFF_FFFF, 2'b11);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R10 mid valid", out_valid, 0);
        check("R10 mid ballot", out_ballot, 0);
        check("R10 mid prefix", (out_prefix == '0), 1);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule